// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

This block decides which hardware thread may retire the instruction at the head of its reorder buffer in the current commit slot. Each thread supplies five inputs: an active bit, a status code, a head-ready flag, a buffer-empty flag and the sequence number of its head instruction. A quasi-static policy input selects one of three arbitration schemes. The block answers combinationally with a valid flag and a thread index.

Under the oldest-first and greedy schemes, the block compares head sequence numbers across the threads that qualify. Under the rotating scheme, it walks a stored ordering of thread indices from the front. When the commit stage confirms that it used a rotating grant, the winner moves to the back of that ordering. An instance built for a single thread ignores the policy logic. It grants that thread whenever its status allows, without looking at head readiness.

Top module: `commit_thread_sel`

## Requirements
- R1: A thread can be selected only if its active bit is set and its 3-bit status is idle (0), running (1) or fetch-trap-pending (4). A thread whose status is buffer-squashing (2) or trap-pending (3) is never selected.
- R2: The policy input is encoded as 0 = greedy, 1 = rotating and 2 = oldest-first. Code 3 behaves as greedy.
- R3: Under oldest-first, a thread qualifies when it meets R1, its head is ready and its buffer is not empty. Among the qualifying threads, the block selects the one with the smallest head sequence number.
- R4: Under oldest-first or greedy, equal head sequence numbers resolve to the lowest thread index.
- R5: Greedy selects exactly the thread that oldest-first selects for the same inputs.
- R6: Under rotating, the block scans its stored ordering from the front. It selects the first thread that meets R1 and has a ready head.
- R7: Reset (rst_ni low) sets the stored ordering to the thread indices in ascending order, with index 0 at the front.
- R8: If accept_i is high at a clock edge while the policy is rotating and sel_valid_o is high, the selected thread moves to the back of the ordering. The other threads keep their relative order.
- R9: An accept_i pulse leaves the ordering unchanged when the policy is not rotating or when no thread is selected.
- R10: When no thread qualifies, sel_valid_o is 0 and sel_tid_o is 0.
- R11: With NUM_THR = 1, the block selects thread 0 exactly when it meets R1, whatever its head-ready and empty flags are.
- R12: The outputs follow input changes within the same cycle, with no register between the inputs and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | Arbitration scheme code |
| active_i | input | NUM_THR | Per-thread active bit |
| status_i | input | 3*NUM_THR | Per-thread status code; thread i at bits [3i+2:3i] |
| head_rdy_i | input | NUM_THR | Head instruction ready to retire |
| rob_empty_i | input | NUM_THR | Reorder buffer of the thread is empty |
| head_seq_i | input | SEQ_W*NUM_THR | Head sequence number; thread i at [SEQ_W*i +: SEQ_W] |
| accept_i | input | 1 | Commit stage used the current grant |
| sel_valid_o | output | 1 | A thread is selected |
| sel_tid_o | output | TID_W | Selected thread index |

## Verification
The embedded properties check the following on every cycle:
- A granted thread always has a permitted status.
- No qualifying thread is older than the oldest-first winner, and no lower-indexed qualifying thread ties with it.
- The stored ordering remains a permutation of the thread indices.
- The ordering changes only on a confirmed rotating grant, and that grant lands at the tail.

The bench scenarios cover:
- The policy encodings and the equivalence of greedy and oldest-first.
- The reset ordering.
- Rotation across several grants, and accept pulses that must be ignored.
- The single-thread bypass.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE       = 3'd0,
    ST_RUNNING    = 3'd1,
    ST_SQUASHING  = 3'd2,
    ST_TRAP_PEND  = 3'd3,
    ST_FTRAP_PEND = 3'd4
  } thr_status_e;

  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_ROTATE = 2'd1,
    POL_OLDEST = 2'd2,
    POL_RSVD   = 2'd3
  } policy_e;

  function automatic logic status_ok(input logic [ST_W-1:0] st);
    return (st == ST_IDLE) || (st == ST_RUNNING) || (st == ST_FTRAP_PEND);
  endfunction
endpackage

// File: rtl/cts_qualify.sv
module cts_qualify
  import cts_pkg::*;
#(
  parameter int unsigned NUM_THR = 4
) (
  input  logic [NUM_THR-1:0]      active_i,
  input  logic [ST_W*NUM_THR-1:0] status_i,
  input  logic [NUM_THR-1:0]      head_rdy_i,
  input  logic [NUM_THR-1:0]      rob_empty_i,
  output logic [NUM_THR-1:0]      elig_o,
  output logic [NUM_THR-1:0]      rot_q_o,
  output logic [NUM_THR-1:0]      old_q_o
);
  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    assign elig_o[g]  = active_i[g] && status_ok(status_i[ST_W*g +: ST_W]);
    assign rot_q_o[g] = elig_o[g] && head_rdy_i[g];
    assign old_q_o[g] = rot_q_o[g] && !rob_empty_i[g];
  end
endmodule

// File: rtl/cts_oldest.sv
module cts_oldest #(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned SEQ_W   = 16,
  localparam int unsigned TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_THR-1:0]       qual_i,
  input  logic [SEQ_W*NUM_THR-1:0] seq_i,
  output logic                     valid_o,
  output logic [TID_W-1:0]         tid_o
);
  logic [SEQ_W-1:0] best_seq;

  // strict less-than keeps the lower index on ties
  always_comb begin
    valid_o  = 1'b0;
    tid_o    = '0;
    best_seq = '0;
    for (int i = 0; i < NUM_THR; i++) begin
      if (qual_i[i] && (!valid_o || seq_i[SEQ_W*i +: SEQ_W] < best_seq)) begin
        valid_o  = 1'b1;
        tid_o    = TID_W'(i);
        best_seq = seq_i[SEQ_W*i +: SEQ_W];
      end
    end
  end

  logic older_seen, tie_lower;
  always_comb begin
    older_seen = 1'b0;
    tie_lower  = 1'b0;
    for (int j = 0; j < NUM_THR; j++) begin
      if (qual_i[j] && seq_i[SEQ_W*j +: SEQ_W] < seq_i[SEQ_W*tid_o +: SEQ_W])
        older_seen = 1'b1;
      if (qual_i[j] && j < int'(tid_o) && seq_i[SEQ_W*j +: SEQ_W] == seq_i[SEQ_W*tid_o +: SEQ_W])
        tie_lower = 1'b1;
    end
  end

  assert_no_older_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (qual_i[tid_o] && !older_seen));
  assert_tie_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !tie_lower);
endmodule

// File: rtl/cts_rotate.sv
module cts_rotate #(
  parameter int unsigned NUM_THR = 4,
  localparam int unsigned TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_THR-1:0] qual_i,
  input  logic               upd_en_i,
  output logic               valid_o,
  output logic [TID_W-1:0]   tid_o
);
  logic [NUM_THR-1:0][TID_W-1:0] order_q, order_d;
  logic [TID_W-1:0] pos;
  logic upd;

  always_comb begin
    valid_o = 1'b0;
    tid_o   = '0;
    pos     = '0;
    for (int i = 0; i < NUM_THR; i++) begin
      if (!valid_o && qual_i[order_q[i]]) begin
        valid_o = 1'b1;
        tid_o   = order_q[i];
        pos     = TID_W'(i);
      end
    end
  end

  assign upd = upd_en_i && valid_o;

  // shift entries behind the winner forward, winner to the tail
  always_comb begin
    order_d = order_q;
    for (int i = 0; i < NUM_THR - 1; i++) begin
      if (i >= int'(pos)) order_d[i] = order_q[i+1];
    end
    order_d[NUM_THR-1] = tid_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_THR; i++) order_q[i] <= TID_W'(i);
    end else if (upd) begin
      order_q <= order_d;
    end
  end

  logic [NUM_THR-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < NUM_THR; i++) seen[order_q[i]] = 1'b1;
  end

  assert_perm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seen) == NUM_THR);
  assert_tail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> order_q[NUM_THR-1] == $past(tid_o));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(order_q));
endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel
  import cts_pkg::*;
#(
  parameter int unsigned NUM_THR = 4,
  parameter int unsigned SEQ_W   = 16,
  localparam int unsigned TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               policy_i,
  input  logic [NUM_THR-1:0]       active_i,
  input  logic [ST_W*NUM_THR-1:0]  status_i,
  input  logic [NUM_THR-1:0]       head_rdy_i,
  input  logic [NUM_THR-1:0]       rob_empty_i,
  input  logic [SEQ_W*NUM_THR-1:0] head_seq_i,
  input  logic                     accept_i,
  output logic                     sel_valid_o,
  output logic [TID_W-1:0]         sel_tid_o
);
  policy_e pol;
  assign pol = policy_e'(policy_i);

  logic [NUM_THR-1:0] elig, rot_q, old_q;
  logic rot_v, old_v;
  logic [TID_W-1:0] rot_tid, old_tid;

  cts_qualify #(.NUM_THR(NUM_THR)) u_qual (
    .active_i   (active_i),
    .status_i   (status_i),
    .head_rdy_i (head_rdy_i),
    .rob_empty_i(rob_empty_i),
    .elig_o     (elig),
    .rot_q_o    (rot_q),
    .old_q_o    (old_q)
  );

  cts_rotate #(.NUM_THR(NUM_THR)) u_rot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .qual_i  (rot_q),
    .upd_en_i(accept_i && (pol == POL_ROTATE) && (NUM_THR > 1)),
    .valid_o (rot_v),
    .tid_o   (rot_tid)
  );

  cts_oldest #(.NUM_THR(NUM_THR), .SEQ_W(SEQ_W)) u_old (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .qual_i (old_q),
    .seq_i  (head_seq_i),
    .valid_o(old_v),
    .tid_o  (old_tid)
  );

  if (NUM_THR == 1) begin : g_single
    assign sel_valid_o = elig[0];
    assign sel_tid_o   = '0;
  end else begin : g_multi
    always_comb begin
      if (pol == POL_ROTATE) begin
        sel_valid_o = rot_v;
        sel_tid_o   = rot_tid;
      end else begin
        sel_valid_o = old_v;
        sel_tid_o   = old_tid;
      end
    end
  end

  logic [ST_W-1:0] sel_st;
  assign sel_st = status_i[ST_W*sel_tid_o +: ST_W];

  assert_grant_ok_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> (active_i[sel_tid_o] && sel_st != ST_SQUASHING && sel_st != ST_TRAP_PEND));
  assert_none_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|elig) |-> (!sel_valid_o && sel_tid_o == '0));
endmodule

// File: tb/sim_commit_thread_sel.sv
module sim_commit_thread_sel;
  localparam int NT = 4;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]      pol;
  logic [NT-1:0]   act, rdy, emp;
  logic [3*NT-1:0] st;
  logic [SW*NT-1:0] seq;
  logic            acc;
  logic            v;
  logic [1:0]      tid;

  commit_thread_sel #(.NUM_THR(NT), .SEQ_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .active_i(act), .status_i(st),
    .head_rdy_i(rdy), .rob_empty_i(emp), .head_seq_i(seq), .accept_i(acc),
    .sel_valid_o(v), .sel_tid_o(tid));

  logic [1:0] s_pol;
  logic       s_act, s_rdy, s_emp, s_acc, s_v, s_tid;
  logic [2:0] s_st;
  logic [SW-1:0] s_seq;

  commit_thread_sel #(.NUM_THR(1), .SEQ_W(SW)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(s_pol), .active_i(s_act), .status_i(s_st),
    .head_rdy_i(s_rdy), .rob_empty_i(s_emp), .head_seq_i(s_seq), .accept_i(s_acc),
    .sel_valid_o(s_v), .sel_tid_o(s_tid));

  int total = 0;
  int bad = 0;

  typedef struct packed {
    logic [1:0]  p;
    logic [3:0]  a;
    logic [11:0] s;
    logic [3:0]  r;
    logic [3:0]  e;
    logic [31:0] q;
    logic        ev;
    logic [1:0]  et;
  } vec_t;

  localparam logic [11:0] ALLR = {3'd1, 3'd1, 3'd1, 3'd1};
  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{2'd2, 4'hF, ALLR, 4'hF, 4'h0, {8'd40, 8'd30, 8'd20, 8'd10}, 1'b1, 2'd0}, // R3
    '{2'd2, 4'hF, ALLR, 4'hF, 4'h0, {8'd5, 8'd30, 8'd20, 8'd10},  1'b1, 2'd3}, // R3
    '{2'd2, 4'hF, ALLR, 4'hA, 4'h0, {8'd5, 8'd30, 8'd20, 8'd10},  1'b1, 2'd3}, // R3
    '{2'd2, 4'hF, {3'd2, 3'd3, 3'd1, 3'd1}, 4'hF, 4'h0, {8'd1, 8'd2, 8'd20, 8'd10}, 1'b1, 2'd0}, // R1
    '{2'd2, 4'hF, ALLR, 4'hF, 4'h0, {8'd7, 8'd7, 8'd9, 8'd9},     1'b1, 2'd2}, // R4
    '{2'd2, 4'hF, ALLR, 4'hF, 4'h4, {8'd7, 8'd7, 8'd9, 8'd9},     1'b1, 2'd3}, // R3 empty
    '{2'd0, 4'hF, ALLR, 4'hF, 4'h0, {8'd5, 8'd30, 8'd20, 8'd10},  1'b1, 2'd3}, // R5
    '{2'd0, 4'h3, ALLR, 4'hF, 4'h0, {8'd1, 8'd2, 8'd20, 8'd10},   1'b1, 2'd0}, // R5 inactive
    '{2'd2, 4'hF, {3'd2, 3'd3, 3'd2, 3'd3}, 4'hF, 4'h0, {8'd1, 8'd2, 8'd3, 8'd4}, 1'b0, 2'd0}, // R10
    '{2'd2, 4'hF, ALLR, 4'h0, 4'h0, {8'd1, 8'd2, 8'd3, 8'd4},     1'b0, 2'd0}, // R10
    '{2'd2, 4'hF, {3'd3, 3'd2, 3'd4, 3'd0}, 4'hF, 4'h0, {8'd2, 8'd1, 8'd40, 8'd50}, 1'b1, 2'd1}, // R1
    '{2'd1, 4'hF, ALLR, 4'hC, 4'h0, {8'd1, 8'd2, 8'd3, 8'd4},     1'b1, 2'd2}, // R6
    '{2'd1, 4'hE, ALLR, 4'hF, 4'h0, {8'd1, 8'd2, 8'd3, 8'd4},     1'b1, 2'd1}, // R6
    '{2'd3, 4'hF, ALLR, 4'hF, 4'h0, {8'd5, 8'd30, 8'd20, 8'd10},  1'b1, 2'd3}  // R2
  };

  task automatic chk(input string tag, input logic gv, input logic [1:0] gt,
                     input logic ev, input logic [1:0] et);
    total++;
    if (gv !== ev || gt !== et) begin
      bad++;
      $display("FAIL %s: valid=%0d tid=%0d expected valid=%0d tid=%0d", tag, gv, gt, ev, et);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic [3:0] a, input logic [11:0] s,
                       input logic [3:0] r, input logic [3:0] e);
    @(negedge clk);
    pol = p; act = a; st = s; rdy = r; emp = e;
    #1;
  endtask

  task automatic pulse_acc();
    @(negedge clk);
    acc = 1'b1;
    @(negedge clk);
    acc = 1'b0;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: valid=x tid=x expected valid=done tid=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pol = 2'd2; act = '0; st = '0; rdy = '0; emp = '0; seq = '0; acc = 1'b0;
    s_pol = 2'd0; s_act = 1'b0; s_st = 3'd0; s_rdy = 1'b0; s_emp = 1'b1; s_acc = 1'b0; s_seq = '0;
    #10;
    chk("R10 reset idle", v, tid, 1'b0, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pol = TBL[i].p; act = TBL[i].a; st = TBL[i].s; rdy = TBL[i].r;
      emp = TBL[i].e; seq = TBL[i].q;
      #1; // R12: same-cycle response
      chk($sformatf("vector %0d", i), v, tid, TBL[i].ev, TBL[i].et);
    end

    // R7 reset order, R8 rotation
    seq = '0;
    drive(2'd1, 4'hF, ALLR, 4'hF, 4'h0);
    chk("R7 initial front", v, tid, 1'b1, 2'd0);
    pulse_acc();
    chk("R8 after first grant", v, tid, 1'b1, 2'd1);
    pulse_acc();
    chk("R8 after second grant", v, tid, 1'b1, 2'd2);
    drive(2'd1, 4'hF, ALLR, 4'h1, 4'h0);
    chk("R6 scan to tid0", v, tid, 1'b1, 2'd0);
    pulse_acc(); // order now 2,3,1,0
    drive(2'd1, 4'hF, ALLR, 4'hF, 4'h0);
    chk("R8 front kept", v, tid, 1'b1, 2'd2);
    drive(2'd1, 4'hF, ALLR, 4'h3, 4'h0);
    chk("R8 relative order", v, tid, 1'b1, 2'd1);

    // R9 ignored accepts
    drive(2'd2, 4'hF, ALLR, 4'hF, 4'h0);
    pulse_acc();
    drive(2'd1, 4'hF, ALLR, 4'hF, 4'h0);
    chk("R9 accept under oldest", v, tid, 1'b1, 2'd2);
    drive(2'd1, 4'hF, ALLR, 4'h0, 4'h0);
    pulse_acc();
    drive(2'd1, 4'hF, ALLR, 4'hF, 4'h0);
    chk("R9 accept without grant", v, tid, 1'b1, 2'd2);

    // R7 reset restores order
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R7 order after reset", v, tid, 1'b1, 2'd0);

    // R11 single-thread bypass
    @(negedge clk);
    s_act = 1'b1; s_st = 3'd1; s_rdy = 1'b0; s_emp = 1'b1;
    #1;
    chk("R11 running not ready", s_v, {1'b0, s_tid}, 1'b1, 2'd0);
    @(negedge clk);
    s_st = 3'd2;
    #1;
    chk("R11 squashing", s_v, {1'b0, s_tid}, 1'b0, 2'd0);
    @(negedge clk);
    s_st = 3'd4; s_pol = 2'd1;
    #1;
    chk("R11 fetch trap pending", s_v, {1'b0, s_tid}, 1'b1, 2'd0);
    @(negedge clk);
    s_act = 1'b0;
    #1;
    chk("R11 inactive", s_v, {1'b0, s_tid}, 1'b0, 2'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule